// File: doc/BRIEF.md
# Programming Status Read Path

This block is the read side of a byte-wide paged nonvolatile memory. When no internal programming period is running, a read returns the stored byte at the addressed location. While the write sequencer reports that programming is in progress, a read does not return array contents. It returns a status byte instead, so that host software can tell when the programming period has finished. Bit 7 of the status byte is the inverse of bit 7 of the last byte written. Bit 6 changes value on every new read access. Bits 5 to 0 repeat the low bits of the last byte written.

The array sits inside the block as a synchronous single-port-read, single-port-write store. The write sequencer commits bytes through a dedicated write port. It also supplies a busy flag and the last byte it accepted. The host side carries active-low chip select, output enable and write enable strobes and an address. The block drives a byte-wide read bus and a separate drive-enable for the pad tristate. All outputs are registered and appear one clock after the inputs that cause them.

Top module: `prog_status_reader`

## Requirements
- R1: While reset is high and in the first cycle after it, `rdata_oe` is 0 and `rdata` is 0x00. The internal toggle state clears to 0.
- R2: `rdata_oe` is 1 in the cycle after one in which `cs_n`=0, `oe_n`=0 and `we_n`=1. In every other case `rdata_oe` is 0 one cycle later and `rdata` is 0x00.
- R3: With `busy`=0, a read returns the stored byte at `addr` one cycle later. Any address may be read, and the strobes may be pulsed or held.
- R4: A cycle with `wr_en`=1 stores `wr_data` at `wr_addr`. A read of that same address in that same cycle returns the previous contents. The new byte is visible from the next read onward.
- R5: With `busy`=1, a read returns in bit 7 the inverse of `last_byte[7]`, whatever the address.
- R6: With `busy`=1, bits 5..0 of a read equal `last_byte[5:0]`, tracking `last_byte` from the cycle before.
- R7: With `busy`=1, bit 6 flips at each access start, meaning a cycle where `cs_n`=0 and `oe_n`=0 after a cycle where that was not true. An access started by either strobe counts. A held access does not flip it.
- R8: Bit 6 presents the toggle state after any flip. The first busy access after reset therefore reads bit 6 = 1.
- R9: With `busy`=0, reads return true array data and accesses do not flip the toggle state. The next busy period continues from the held value.
- R10: An access already in progress when `busy` rises does not count as an access start. It reads the held toggle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; must be high to read |
| addr | input | AW | Read address |
| busy | input | 1 | Programming period in progress (from write sequencer) |
| last_byte | input | 8 | Last byte accepted by the write sequencer |
| wr_en | input | 1 | Array commit strobe from the write sequencer |
| wr_addr | input | AW | Array commit address |
| wr_data | input | 8 | Array commit data |
| rdata | output | 8 | Read bus value |
| rdata_oe | output | 1 | Read bus drive enable |

## Verification
Idle reads are tried over a spread of addresses with the output enable pulsed, held and skipped. This separates the one-cycle array latency and the drive-enable decode from the data value. Each single strobe that blocks a read is applied alone, and so is a low write enable, which shows that every one of them forces the bus quiet. Busy reads start once by the output enable and once by the chip select, are held across several cycles, change address, and see `last_byte` change. This tells a per-access flip apart from a per-cycle flip and shows that the status ignores the address. Busy periods are split by idle accesses, and one busy period begins under an access that is already open. These cases tell apart a toggle that holds its value, one that resets, and one that counts a level instead of an edge.

// File: rtl/prog_status_pkg.sv
package prog_status_pkg;
  localparam int BYTE_W   = 8;
  localparam int POLL_BIT = BYTE_W - 1;
  localparam int TGL_BIT  = BYTE_W - 2;

  // Status byte shown during programming: inverted top bit, toggle, low bits.
  function automatic logic [BYTE_W-1:0] status_byte(input logic [BYTE_W-1:0] last,
                                                     input logic              tgl);
    logic [BYTE_W-1:0] s;
    s           = last;
    s[POLL_BIT] = ~last[POLL_BIT];
    s[TGL_BIT]  = tgl;
    return s;
  endfunction
endpackage

// File: rtl/status_array_store.sv
module status_array_store #(
  parameter int AW = 8
) (
  input  logic                                 clk,
  input  logic                                 wr_en,
  input  logic [AW-1:0]                        wr_addr,
  input  logic [prog_status_pkg::BYTE_W-1:0]   wr_data,
  input  logic [AW-1:0]                        rd_addr,
  output logic [prog_status_pkg::BYTE_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [prog_status_pkg::BYTE_W-1:0] mem [DEPTH];

  // Read-first synchronous RAM: maps onto a block RAM with registered output.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/access_toggle.sv
module access_toggle (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic oe_n,
  input  logic busy,
  output logic tgl_now
);
  logic strobe;
  logic strobe_q;
  logic tgl_q;
  logic start;

  assign strobe  = ~cs_n & ~oe_n;
  assign start   = strobe & ~strobe_q & busy;
  assign tgl_now = tgl_q ^ start;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      tgl_q    <= 1'b0;
    end else begin
      strobe_q <= strobe;
      tgl_q    <= tgl_now;
    end
  end
endmodule

// File: rtl/read_out_stage.sv
module read_out_stage (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                rd_req,
  input  logic                                busy,
  input  logic [prog_status_pkg::BYTE_W-1:0]  last_byte,
  input  logic                                tgl_now,
  input  logic [prog_status_pkg::BYTE_W-1:0]  arr_data,
  output logic [prog_status_pkg::BYTE_W-1:0]  rdata,
  output logic                                rdata_oe
);
  import prog_status_pkg::*;

  logic              oe_q;
  logic              busy_q;
  logic [BYTE_W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      busy_q <= 1'b0;
      stat_q <= '0;
    end else begin
      oe_q   <= rd_req;
      busy_q <= busy;
      stat_q <= status_byte(last_byte, tgl_now);
    end
  end

  // Selection between two registered sources; the RAM output is its own register.
  assign rdata    = oe_q ? (busy_q ? stat_q : arr_data) : '0;
  assign rdata_oe = oe_q;
endmodule

// File: rtl/prog_status_reader.sv
module prog_status_reader #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  input  logic [7:0]    last_byte,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rdata,
  output logic          rdata_oe
);
  logic       rd_req;
  logic       tgl_now;
  logic [7:0] arr_data;

  assign rd_req = ~cs_n & ~oe_n & we_n;

  status_array_store #(.AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (addr),
    .rd_data (arr_data)
  );

  access_toggle u_tgl (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .busy    (busy),
    .tgl_now (tgl_now)
  );

  read_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .busy      (busy),
    .last_byte (last_byte),
    .tgl_now   (tgl_now),
    .arr_data  (arr_data),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe)
  );
endmodule

// File: rtl/prog_status_checker.sv
module prog_status_checker (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       busy,
  input logic [7:0] last_byte,
  input logic [7:0] rdata,
  input logic       rdata_oe
);
  logic rd;
  assign rd = !cs_n && !oe_n && we_n;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rdata_oe && rdata == 8'h00));

  a_r2_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    rd |=> rdata_oe);

  a_r2_quiet_otherwise: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (!rdata_oe && rdata == 8'h00));

  // R5 and R6: status bits derived from the last written byte
  a_r5_poll_inverted: assert property (@(posedge clk) disable iff (rst)
    (rd && busy) |=> (rdata[7] == !$past(last_byte[7]) &&
                      rdata[5:0] == $past(last_byte[5:0])));

  a_r7_held_access_steady: assert property (@(posedge clk) disable iff (rst)
    (rd && busy && $past(rd) && $past(busy) && !$past(rst))
      |=> (rdata[6] == $past(rdata[6])));
endmodule

bind prog_status_reader prog_status_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .busy      (busy),
  .last_byte (last_byte),
  .rdata     (rdata),
  .rdata_oe  (rdata_oe)
);

// File: tb/prog_status_reader_bench.sv
module prog_status_reader_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          busy = 1'b0;
  logic [7:0]    last_byte = 8'h00;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = 8'h00;
  logic [7:0]    rdata;
  logic          rdata_oe;

  always #5 clk = ~clk;

  prog_status_reader #(.AW(AW)) u_prog_status_reader (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .busy(busy), .last_byte(last_byte), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Behavioural reference
  logic [7:0] m_mem [256];
  bit         m_tgl, m_prev, m_s, e_valid = 1'b0;
  logic [7:0] e_d;
  bit         e_oe;

  always @(posedge clk) begin
    if (rst) begin
      m_tgl = 0; m_prev = 0; e_oe = 0; e_d = 8'h00;
    end else begin
      m_s = !cs_n && !oe_n;
      if (busy && m_s && !m_prev) m_tgl = !m_tgl;
      m_prev = m_s;
      e_oe = m_s && we_n;
      if (!e_oe)     e_d = 8'h00;
      else if (busy) e_d = {!last_byte[7], m_tgl, last_byte[5:0]};
      else           e_d = m_mem[addr];
    end
    if (wr_en) m_mem[wr_addr] = wr_data;
    e_valid = 1'b1;
  end

  always @(negedge clk) begin
    if (e_valid && !done) begin
      n_cmp++;
      if (rdata_oe !== e_oe || rdata !== e_d) begin
        n_bad++;
        $display("FAIL %s: cycle compare got oe=%0b data=%h expected oe=%0b data=%h",
                 cur_req, rdata_oe, rdata, e_oe, e_d);
      end
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1", {7'd0, rdata_oe}, 8'h00);
    chk("R1", rdata, 8'h00);

    cur_req = "R4";
    for (int i = 0; i < 32; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(i);
      tick();
    end
    wr_en = 1'b0;

    cur_req = "R3";
    cs_n = 1'b0;
    for (int i = 0; i < 32; i++) begin
      oe_n = (i % 3 == 2); addr = AW'(i ^ 5);
      tick();
    end
    oe_n = 1'b0; addr = 8'd3;
    tick();
    chk("R3", rdata, pat(3));

    cur_req = "R2";
    cs_n = 1'b1; tick();
    cs_n = 1'b0; oe_n = 1'b1; tick();
    oe_n = 1'b0; we_n = 1'b0; tick();
    chk("R2", {rdata_oe, rdata[6:0]}, 8'h00);
    chk("R2", rdata, 8'h00);
    we_n = 1'b1;

    cur_req = "R4";
    addr = 8'd7; wr_en = 1'b1; wr_addr = 8'd7; wr_data = 8'h99;
    tick();
    chk("R4", rdata, pat(7));
    wr_en = 1'b0;
    tick();
    chk("R4", rdata, 8'h99);

    cur_req = "R8";
    oe_n = 1'b1; tick();
    busy = 1'b1; last_byte = 8'hC5; oe_n = 1'b0; addr = 8'd9;
    tick();
    chk("R8", rdata, 8'h45);

    cur_req = "R7";
    for (int k = 0; k < 6; k++) begin
      oe_n = 1'b1; tick();
      oe_n = 1'b0; tick();
      tick();
    end
    cur_req = "R5";
    for (int k = 0; k < 3; k++) begin
      cs_n = 1'b1; tick();
      cs_n = 1'b0; addr = AW'(k * 11); tick();
    end
    cur_req = "R6";
    last_byte = 8'h6B; tick(); tick();

    cur_req = "R9";
    busy = 1'b0;
    oe_n = 1'b1; tick();
    oe_n = 1'b0; addr = 8'd12; tick();
    chk("R9", rdata, pat(12));
    oe_n = 1'b1; tick();
    oe_n = 1'b0; addr = 8'd20; tick();
    chk("R9", rdata, pat(20));
    oe_n = 1'b1; tick();
    busy = 1'b1; last_byte = 8'h3A; tick();
    oe_n = 1'b0; tick();
    chk("R9", rdata, 8'hFA);

    cur_req = "R10";
    oe_n = 1'b1; tick();
    busy = 1'b0; oe_n = 1'b0; tick(); tick();
    busy = 1'b1; last_byte = 8'h15; tick();
    chk("R10", rdata, 8'hD5);
    tick();
    chk("R10", rdata, 8'hD5);

    busy = 1'b0; oe_n = 1'b1; cs_n = 1'b1;
    tick(); tick();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule